// File: doc/BRIEF.md
# Multi-Channel DMA Register Bank

This block holds the software-visible setup and progress state of an eight-channel DMA engine that serves USB endpoints. A host processor reaches it through a plain register bus that has an address, write data, a size code, a write strobe, a read strobe and combinational read data. Every channel owns a 16-bit control word, a 32-bit memory address and a 32-bit byte count. One shared byte records which channels have raised an interrupt. A single interrupt line is the OR of that byte.

The bank presents each channel's control word, address and count to a per-channel transfer engine. It takes that engine's progress reports: a live address and count, a completion pulse and a bus-fault pulse. Software loads the address and count and then writes the control word with the enable bit set, which starts the channel. When a transfer ends, whether normally or by fault, the channel stops by itself and leaves its final address and count readable. Software can work out the moved length from the address that advanced.

The window begins at offset 0x200. The interrupt byte sits at the window base. Channel n occupies sixteen bytes from 0x200 + 16n. Its control word is at +4, its address at +8 and its count at +C.

Top module: `dmareg_bank`

## Requirements
- R1: After reset every control, address, count and interrupt-status bit reads zero, all configuration outputs are zero and irq_o is low.
- R2: Channel n's control, address and count registers read back at 0x200+16n plus 4, 8 and 12. The interrupt byte reads at 0x200 in bits 7:0. Any other offset in the window reads zero.
- R3: The control word writes and reads back in bits 10:9 and 7:0. Bit 0 is enable, bit 1 is direction, bit 2 is mode, bit 3 is interrupt enable, bits 7:4 are the endpoint and bits 10:9 are the burst type. Bits 15:11 read zero, and bit 8 is not writable. The word appears unchanged on cfg_ctrl.
- R4: bus_size 0 writes one byte lane, selected by addr[1:0]. Size 1 writes a halfword, the upper one when addr[1] is 1. Sizes 2 and 3 write all four lanes. Lane k holds wdata[8k+7:8k], and lanes that are not addressed keep their old contents.
- R5: With ALIGN_ADDR=1, a software write to an address register stores bits 1:0 as zero.
- R6: While a channel's enable bit is 1, an engine update loads the engine's address and count into that channel's registers. While enable is 0, engine updates are ignored.
- R7: An engine completion on an enabled channel clears its enable bit and leaves the address and count unchanged.
- R8: An engine bus fault on an enabled channel clears enable and sets control bit 8. Any later software write to that control word clears bit 8.
- R9: An enabled channel's completion or fault sets interrupt-status bit n when control bit 3 is 1. It sets nothing when bit 3 is 0.
- R10: A read of the interrupt byte returns its value and clears it. A completion or fault in the same cycle as that read stays pending. irq_o is high whenever any status bit is set.
- R11: Writing zero to a channel's control, address and count registers aborts it. The registers read zero, and later completions and updates from the engine have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | AW | Byte address of the access |
| bus_wdata | input | 32 | Write data, lane k in bits 8k+7:8k |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (the interrupt byte clears when it is read) |
| bus_rdata | output | 32 | Read data for bus_addr |
| eng_upd | input | NUM_CH | Per-channel progress update strobe |
| eng_done | input | NUM_CH | Per-channel completion pulse |
| eng_err | input | NUM_CH | Per-channel bus-fault pulse |
| eng_addr | input | NUM_CH*32 | Live address from each engine |
| eng_count | input | NUM_CH*32 | Live count from each engine |
| cfg_ctrl | output | NUM_CH*16 | Control word of each channel |
| cfg_addr | output | NUM_CH*32 | Address register of each channel |
| cfg_count | output | NUM_CH*32 | Count register of each channel |
| irq_o | output | 1 | Interrupt, high while any status bit is set |

## Verification
On every cycle the assertions check several rules. A completion or fault on a running channel must stop it, and a fault must leave the error flag set. The address of an idle channel must hold steady, and a masked address write must land aligned. A status bit that is raised must be captured, a clearing read must keep only the events of that same cycle, and each write must touch a legal number of byte lanes. Some behaviour only the bench scenarios can show: the address map itself, which lanes a narrow write merges, the read-back value of the control fields, and the end of an abort, where the engine's later completion does not reach the interrupt byte.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
  localparam int WORD_W = 32;
  localparam int CTRL_W = 16;
  localparam int LANES  = WORD_W / 8;

  // bit positions inside a channel control word
  localparam int CB_RUN  = 0;
  localparam int CB_IRQE = 3;
  localparam int CB_FLT  = 8;

  // bits software may write in a control word
  localparam logic [CTRL_W-1:0] CTRL_WMASK = 16'h06FF;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD2 = 2'd3
  } bus_size_e;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_ADDR  = 2'd2,
    SEL_COUNT = 2'd3
  } reg_sel_e;

  function automatic logic [WORD_W-1:0] lane_merge(
    input logic [WORD_W-1:0] old_v,
    input logic [WORD_W-1:0] new_v,
    input logic [LANES-1:0]  be
  );
    logic [WORD_W-1:0] r;
    r = old_v;
    for (int k = 0; k < LANES; k++) begin
      if (be[k]) r[8*k +: 8] = new_v[8*k +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/dmareg_decode.sv
module dmareg_decode
  import dmareg_pkg::*;
#(
  parameter int          NUM_CH = 8,
  parameter int          AW     = 12,
  parameter logic [AW-1:0] BASE = 12'h200,
  localparam int         CHW    = $clog2(NUM_CH),
  localparam int         WINB   = CHW + 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  addr,
  input  logic [1:0]     size,
  input  logic           we,
  output logic           hit_stat,
  output logic [CHW-1:0] ch_idx,
  output reg_sel_e       reg_sel,
  output logic [LANES-1:0] be
);
  logic       in_win;
  logic [1:0] word_ofs;

  always_comb begin
    in_win   = (addr[AW-1:WINB] == BASE[AW-1:WINB]);
    ch_idx   = addr[WINB-1:4];
    word_ofs = addr[3:2];
    hit_stat = in_win && (ch_idx == '0) && (word_ofs == 2'd0);
    reg_sel  = SEL_NONE;
    if (in_win) begin
      case (word_ofs)
        2'd1:    reg_sel = SEL_CTRL;
        2'd2:    reg_sel = SEL_ADDR;
        2'd3:    reg_sel = SEL_COUNT;
        default: reg_sel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    case (bus_size_e'(size))
      SZ_BYTE: be = 4'b0001 << addr[1:0];
      SZ_HALF: be = addr[1] ? 4'b1100 : 4'b0011;
      default: be = 4'b1111;
    endcase
  end

  // R4
  lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> ($countones(be) == 1 || $countones(be) == 2 || $countones(be) == 4));
endmodule

// File: rtl/dmareg_chan.sv
module dmareg_chan
  import dmareg_pkg::*;
#(
  parameter bit ALIGN_ADDR = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_addr,
  input  logic              wr_count,
  input  logic [LANES-1:0]  be,
  input  logic [WORD_W-1:0] wdata,
  input  logic              eng_upd,
  input  logic              eng_done,
  input  logic              eng_err,
  input  logic [WORD_W-1:0] eng_addr,
  input  logic [WORD_W-1:0] eng_count,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [WORD_W-1:0] addr_q,
  output logic [WORD_W-1:0] count_q,
  output logic              irq_evt
);
  logic [CTRL_W-1:0] ctrl_d;
  logic [WORD_W-1:0] addr_d, count_d, ctrl_merge;
  logic              running, finish;
  logic              ctrl_en, addr_en, count_en;

  always_comb begin
    running    = ctrl_q[CB_RUN];
    finish     = running && (eng_done || eng_err);
    irq_evt    = finish && ctrl_q[CB_IRQE];
    ctrl_merge = lane_merge({{(WORD_W-CTRL_W){1'b0}}, ctrl_q}, wdata, be);

    ctrl_d = ctrl_q;
    if (finish) begin
      ctrl_d[CB_RUN] = 1'b0;
      if (eng_err) ctrl_d[CB_FLT] = 1'b1;
    end
    if (wr_ctrl) ctrl_d = ctrl_merge[CTRL_W-1:0] & CTRL_WMASK;

    addr_d  = addr_q;
    count_d = count_q;
    if (running && eng_upd) begin
      addr_d  = eng_addr;
      count_d = eng_count;
    end
    if (wr_addr) begin
      addr_d = lane_merge(addr_q, wdata, be);
      if (ALIGN_ADDR) addr_d[1:0] = 2'b00;
    end
    if (wr_count) count_d = lane_merge(count_q, wdata, be);

    ctrl_en  = wr_ctrl || finish;
    addr_en  = wr_addr || (running && eng_upd);
    count_en = wr_count || (running && eng_upd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      addr_q  <= '0;
      count_q <= '0;
    end else begin
      if (ctrl_en)  ctrl_q  <= ctrl_d;
      if (addr_en)  addr_q  <= addr_d;
      if (count_en) count_q <= count_d;
    end
  end

  // R7
  done_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CB_RUN] && (eng_done || eng_err) && !wr_ctrl) |=> !ctrl_q[CB_RUN]);

  // R8
  fault_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CB_RUN] && eng_err && !wr_ctrl) |=> ctrl_q[CB_FLT]);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[CB_RUN] && !wr_addr) |=> $stable(addr_q));

  // R5
  align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ALIGN_ADDR && wr_addr) |=> (addr_q[1:0] == 2'b00));
endmodule

// File: rtl/dmareg_irq.sv
module dmareg_irq #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_vec,
  input  logic              rd_clr,
  output logic [NUM_CH-1:0] status_q,
  output logic              irq_o
);
  logic [NUM_CH-1:0] status_d;
  logic              stat_en;

  always_comb begin
    status_d = (rd_clr ? '0 : status_q) | set_vec;
    stat_en  = rd_clr || (|set_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       status_q <= '0;
    else if (stat_en) status_q <= status_d;
  end

  assign irq_o = |status_q;

  // R9
  set_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  // R10
  clear_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> (status_q == $past(set_vec)));
endmodule

// File: rtl/dmareg_bank.sv
module dmareg_bank
  import dmareg_pkg::*;
#(
  parameter int            NUM_CH     = 8,
  parameter int            AW         = 12,
  parameter logic [AW-1:0] BASE       = 12'h200,
  parameter bit            ALIGN_ADDR = 1'b1,
  localparam int           CHW        = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [AW-1:0]            bus_addr,
  input  logic [WORD_W-1:0]        bus_wdata,
  input  logic [1:0]               bus_size,
  input  logic                     bus_we,
  input  logic                     bus_re,
  output logic [WORD_W-1:0]        bus_rdata,
  input  logic [NUM_CH-1:0]        eng_upd,
  input  logic [NUM_CH-1:0]        eng_done,
  input  logic [NUM_CH-1:0]        eng_err,
  input  logic [NUM_CH*WORD_W-1:0] eng_addr,
  input  logic [NUM_CH*WORD_W-1:0] eng_count,
  output logic [NUM_CH*CTRL_W-1:0] cfg_ctrl,
  output logic [NUM_CH*WORD_W-1:0] cfg_addr,
  output logic [NUM_CH*WORD_W-1:0] cfg_count,
  output logic                     irq_o
);
  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  logic             hit_stat;
  logic [CHW-1:0]   ch_idx;
  reg_sel_e         reg_sel;
  logic [LANES-1:0] be;

  dmareg_decode #(.NUM_CH(NUM_CH), .AW(AW), .BASE(BASE)) u_dec (
    .clk      (clk),
    .rst_n    (srst_n),
    .addr     (bus_addr),
    .size     (bus_size),
    .we       (bus_we),
    .hit_stat (hit_stat),
    .ch_idx   (ch_idx),
    .reg_sel  (reg_sel),
    .be       (be)
  );

  logic [CTRL_W-1:0] ctrl_arr  [NUM_CH];
  logic [WORD_W-1:0] addr_arr  [NUM_CH];
  logic [WORD_W-1:0] count_arr [NUM_CH];
  logic [NUM_CH-1:0] irq_set;
  logic [NUM_CH-1:0] status_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic sel_me;
    assign sel_me = bus_we && (ch_idx == CHW'(g));

    dmareg_chan #(.ALIGN_ADDR(ALIGN_ADDR)) u_chan (
      .clk       (clk),
      .rst_n     (srst_n),
      .wr_ctrl   (sel_me && (reg_sel == SEL_CTRL)),
      .wr_addr   (sel_me && (reg_sel == SEL_ADDR)),
      .wr_count  (sel_me && (reg_sel == SEL_COUNT)),
      .be        (be),
      .wdata     (bus_wdata),
      .eng_upd   (eng_upd[g]),
      .eng_done  (eng_done[g]),
      .eng_err   (eng_err[g]),
      .eng_addr  (eng_addr[g*WORD_W +: WORD_W]),
      .eng_count (eng_count[g*WORD_W +: WORD_W]),
      .ctrl_q    (ctrl_arr[g]),
      .addr_q    (addr_arr[g]),
      .count_q   (count_arr[g]),
      .irq_evt   (irq_set[g])
    );

    assign cfg_ctrl[g*CTRL_W +: CTRL_W]  = ctrl_arr[g];
    assign cfg_addr[g*WORD_W +: WORD_W]  = addr_arr[g];
    assign cfg_count[g*WORD_W +: WORD_W] = count_arr[g];
  end

  dmareg_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk      (clk),
    .rst_n    (srst_n),
    .set_vec  (irq_set),
    .rd_clr   (bus_re && hit_stat),
    .status_q (status_q),
    .irq_o    (irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit_stat) begin
      bus_rdata[NUM_CH-1:0] = status_q;
    end else begin
      case (reg_sel)
        SEL_CTRL:  bus_rdata[CTRL_W-1:0] = ctrl_arr[ch_idx];
        SEL_ADDR:  bus_rdata = addr_arr[ch_idx];
        SEL_COUNT: bus_rdata = count_arr[ch_idx];
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: tb/dmareg_bank_tb.sv
module dmareg_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [1:0]  bus_size;
  logic        bus_we, bus_re;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] eng_upd, eng_done, eng_err;
  logic [NCH*32-1:0] eng_addr, eng_count;
  logic [NCH*16-1:0] cfg_ctrl;
  logic [NCH*32-1:0] cfg_addr, cfg_count;
  logic        irq_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmareg_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_size(bus_size), .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .eng_upd(eng_upd), .eng_done(eng_done), .eng_err(eng_err),
    .eng_addr(eng_addr), .eng_count(eng_count), .cfg_ctrl(cfg_ctrl),
    .cfg_addr(cfg_addr), .cfg_count(cfg_count), .irq_o(irq_o)
  );

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_item_t;

  exp_item_t sb_q[$];
  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  function automatic logic [11:0] ra(int ch, int ofs);
    return 12'(32'h200 + ch * 16 + ofs);
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares every read against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (bus_re) begin
        if (sb_q.size() == 0) begin
          check(bus_rdata, 32'hDEADBEEF, "scoreboard empty");
        end else begin
          exp_item_t it;
          it = sb_q.pop_front();
          check(bus_rdata, it.exp, it.tag);
        end
      end
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [1:0] sz);
    bus_addr = a; bus_wdata = d; bus_size = sz; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    exp_item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    bus_addr = a; bus_size = 2'd2; bus_re = 1'b1;
    @(posedge clk); #1;
    bus_re = 1'b0;
  endtask

  task automatic eng(int ch, bit upd, bit done, bit err, logic [31:0] a, logic [31:0] c);
    eng_upd[ch] = upd; eng_done[ch] = done; eng_err[ch] = err;
    eng_addr[ch*32 +: 32] = a; eng_count[ch*32 +: 32] = c;
    @(posedge clk); #1;
    eng_upd = '0; eng_done = '0; eng_err = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_size = '0;
    bus_we = 1'b0; bus_re = 1'b0;
    eng_upd = '0; eng_done = '0; eng_err = '0; eng_addr = '0; eng_count = '0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (3) @(posedge clk); #1;

    // R1 reset state
    check({31'b0, irq_o}, 32'h0, "R1 irq after reset");
    check(32'(cfg_ctrl[63:0]), 32'h0, "R1 cfg_ctrl after reset");
    rd(ra(0, 0), 32'h0, "R1 status after reset");
    rd(ra(0, 4), 32'h0, "R1 ch0 ctrl after reset");
    rd(ra(7, 8), 32'h0, "R1 ch7 addr after reset");

    // R5 / R2 map and alignment
    wr(ra(3, 8), 32'h1000_0003, 2'd2);
    rd(ra(3, 8), 32'h1000_0000, "R5 address low bits masked");
    wr(ra(3, 12), 32'h0000_0040, 2'd2);
    rd(ra(3, 12), 32'h0000_0040, "R2 ch3 count readback");
    rd(ra(1, 0), 32'h0, "R2 unmapped offset reads zero");

    // R3 control field mask
    wr(ra(3, 4), 32'h0000_FFFF, 2'd2);
    rd(ra(3, 4), 32'h0000_06FF, "R3 control writable bits");
    wr(ra(3, 4), 32'h0000_063B, 2'd2);
    check(32'(cfg_ctrl[3*16 +: 16]), 32'h063B, "R3 cfg_ctrl ch3");

    // R4 lane writes
    wr(ra(2, 8), 32'h1122_3344, 2'd2);
    wr(ra(2, 9), 32'h0000_AA00, 2'd0);
    rd(ra(2, 8), 32'h1122_AA44, "R4 byte lane 1 write");
    wr(ra(2, 10), 32'hBBCC_0000, 2'd1);
    rd(ra(2, 8), 32'hBBCC_AA44, "R4 upper halfword write");

    // R6 engine updates
    eng(3, 1, 0, 0, 32'h1000_0020, 32'h0000_0020);
    rd(ra(3, 8), 32'h1000_0020, "R6 live address update");
    rd(ra(3, 12), 32'h0000_0020, "R6 live count update");
    eng(2, 1, 0, 0, 32'h5555_5554, 32'h1);
    rd(ra(2, 8), 32'hBBCC_AA44, "R6 idle channel ignores update");

    // R7 / R9 / R10 completion
    eng(3, 0, 1, 0, 32'h0, 32'h0);
    rd(ra(3, 4), 32'h0000_063A, "R7 enable cleared on done");
    rd(ra(3, 8), 32'h1000_0020, "R7 address held after done");
    check({31'b0, irq_o}, 32'h1, "R10 irq raised");
    rd(ra(0, 0), 32'h0000_0008, "R9 status bit 3");
    rd(ra(0, 0), 32'h0, "R10 status cleared by read");
    check({31'b0, irq_o}, 32'h0, "R10 irq low after clear");

    // R8 fault with interrupt disabled
    wr(ra(5, 4), 32'h0000_0051, 2'd2);
    eng(5, 0, 0, 1, 32'h0, 32'h0);
    rd(ra(5, 4), 32'h0000_0150, "R8 fault flag and stop");
    rd(ra(0, 0), 32'h0, "R9 no status when irq disabled");
    wr(ra(5, 4), 32'h0000_0059, 2'd2);
    rd(ra(5, 4), 32'h0000_0059, "R8 fault flag cleared by write");
    eng(5, 0, 1, 0, 32'h0, 32'h0);
    rd(ra(0, 0), 32'h0000_0020, "R9 status bit 5");

    // R10 event in the same cycle as a clearing read
    wr(ra(4, 4), 32'h0000_0049, 2'd2);
    wr(ra(1, 4), 32'h0000_0019, 2'd2);
    eng(4, 0, 1, 0, 32'h0, 32'h0);
    begin
      exp_item_t it;
      it.exp = 32'h0000_0010; it.tag = "R10 read during new event";
      sb_q.push_back(it);
      bus_addr = ra(0, 0); bus_size = 2'd2; bus_re = 1'b1; eng_done[1] = 1'b1;
      @(posedge clk); #1;
      bus_re = 1'b0; eng_done = '0;
    end
    check({31'b0, irq_o}, 32'h1, "R10 irq stays high for new event");
    rd(ra(0, 0), 32'h0000_0002, "R10 same-cycle event kept");

    // R11 abort
    wr(ra(6, 8), 32'h0000_3000, 2'd2);
    wr(ra(6, 12), 32'h0000_0080, 2'd2);
    wr(ra(6, 4), 32'h0000_0069, 2'd2);
    wr(ra(6, 4), 32'h0, 2'd2);
    wr(ra(6, 8), 32'h0, 2'd2);
    wr(ra(6, 12), 32'h0, 2'd2);
    eng(6, 1, 1, 0, 32'h0000_3040, 32'h40);
    rd(ra(6, 4), 32'h0, "R11 control zero after abort");
    rd(ra(6, 8), 32'h0, "R11 address unaffected after abort");
    rd(ra(0, 0), 32'h0, "R11 no status after abort");
    check({31'b0, irq_o}, 32'h0, "R11 irq low after abort");

    @(posedge clk); #1;
    if (sb_q.size() != 0) check(32'(sb_q.size()), 32'h0, "scoreboard drained");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule